// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides which clocks of a small 8-bit microcontroller stay alive while it sleeps, and when they come back. Software first writes a two-bit mode field, then the CPU issues a stop strobe. If no interrupt request is pending at that moment, the controller drops into one of three sleep states. Each state gates a different set of clock enables: CPU clock, main oscillator, prescaler, Timer0 clock (with a select for the slow divide-by-2048 tap) and the internal RC oscillator.

Each sleep state accepts its own set of wake events. Both external interrupts count in every state. A Timer0 match counts only in the wake-up-timer state, and an RC-watchdog event only in the RC-watchdog state. When waking from a state that had the main oscillator off, the controller first re-enables the oscillator. It then counts a programmable number of cycles before the CPU clock restarts. When the CPU clock returns, a one-cycle pulse reports which source caused the wake.

The controller runs from an always-on clock with a synchronous active-high reset. Because the CPU clock is gated in every sleep state, the CPU holds its program counter, register and port state while asleep. It resumes at the instruction after the stop.

Top module: `lpm_seq`

## Requirements
- R1: While reset is high, and after it, the controller is active. The enables cpu_clk_en, osc_en, presc_en, tmr0_clk_en and rcosc_en are 1, tmr0_slow_sel is 0, mode_q is 00 and wake_pulse is 0.
- R2: A sleep state is entered on the clock edge that samples stop_req while the controller is active and irq_flags is all zero. mode_q selects the state: 00 is full stop, 01 is RC-watchdog and 1X is wake-up-timer. Writing the mode alone leaves every enable on.
- R3: If any bit of irq_flags is set when stop_req is sampled, the controller stays active and cpu_clk_en stays 1.
- R4: In full stop, all five enables and tmr0_slow_sel are 0. Only int0 or int1 releases this state; tmr0_match and rcwdt_evt have no effect.
- R5: In wake-up-timer mode, osc_en, tmr0_clk_en and tmr0_slow_sel are 1, and cpu_clk_en, presc_en and rcosc_en are 0. int0, int1 or tmr0_match release this state; rcwdt_evt is ignored.
- R6: In RC-watchdog mode, only rcosc_en is 1. int0, int1 or rcwdt_evt release this state; tmr0_match is ignored.
- R7: A release from full stop or RC-watchdog mode first enters a countdown. During the countdown only osc_en is 1. cpu_clk_en returns stab_cycles+1 edges after the edge that sampled the wake event, where stab_cycles is captured at that edge.
- R8: A release from wake-up-timer mode sets cpu_clk_en on the edge that samples the wake event.
- R9: wake_pulse is high for exactly one cycle, in the first cycle that cpu_clk_en is back. wake_src then gives the source: 0 for int0, 1 for int1, 2 for Timer0 match, 3 for RC-watchdog. When events coincide, int0 wins over int1, and int1 wins over the mode's timer event.
- R10: Wake events that arrive while the controller is active produce no wake_pulse.
- R11: A stop strobe or a wake event during the countdown neither shortens nor lengthens it, and causes no extra pulse.
- R12: mode_q takes mode_wdata on mode_wr only while active. In every sleep state, writes are ignored and mode_q holds its value.
- R13: Reset asserted in any sleep state returns the controller to active, with all enables on and mode_q at 00, on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | New mode value |
| stop_req | input | 1 | Stop command strobe from the CPU |
| irq_flags | input | IRQ_W | Pending interrupt request flags |
| int0 | input | 1 | External interrupt 0 wake event |
| int1 | input | 1 | External interrupt 1 wake event |
| tmr0_match | input | 1 | Timer0 match wake event |
| rcwdt_evt | input | 1 | RC-watchdog wake event |
| stab_cycles | input | CNT_W | Oscillator settling count |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Main oscillator enable |
| presc_en | output | 1 | Prescaler output enable |
| tmr0_clk_en | output | 1 | Timer0 clock enable |
| tmr0_slow_sel | output | 1 | Timer0 fed from divide-by-2048 tap only |
| rcosc_en | output | 1 | Internal RC oscillator enable |
| wake_pulse | output | 1 | One-cycle pulse when the CPU clock returns |
| wake_src | output | 2 | Code of the releasing source |
| mode_q | output | 2 | Current mode field |

## Verification
The bench checks that the stop strobe is vetoed by any pending flag; a design that ignored the veto would gate the CPU clock with an interrupt waiting. In each state it fires the wake events that the state must not accept, for example a Timer0 match in full stop or a watchdog event in timer mode; a loose qualifier would wake early and emit an unexpected pulse. The countdown is timed to the exact cycle, with stray stop strobes and interrupts injected while it runs; an off-by-one or a restarted counter moves the pulse. Coinciding events check the source priority, and a reset taken in mid-sleep shows whether all clocks come back at once.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_ACT  = 3'd0,
        ST_STOP = 3'd1,
        ST_WKT  = 3'd2,
        ST_RCW  = 3'd3,
        ST_STAB = 3'd4
    } lpm_state_e;

    typedef enum logic [1:0] {
        SRC_INT0  = 2'd0,
        SRC_INT1  = 2'd1,
        SRC_TMR0  = 2'd2,
        SRC_RCWDT = 2'd3
    } wake_src_e;

    typedef struct packed {
        logic cpu;
        logic osc;
        logic presc;
        logic tmr0;
        logic tmr0_slow;
        logic rcosc;
    } clk_en_t;

    localparam int MODE_W = 2;

    // Upper bit set picks the timer-driven sleep; 01 keeps the RC oscillator.
    function automatic lpm_state_e mode_to_state(input logic [MODE_W-1:0] m);
        if (m[1])          return ST_WKT;
        else if (m[0])     return ST_RCW;
        else               return ST_STOP;
    endfunction

    function automatic clk_en_t gate_map(input lpm_state_e s);
        clk_en_t e;
        e = '0;
        case (s)
            ST_ACT:  begin e.cpu = 1'b1; e.osc = 1'b1; e.presc = 1'b1;
                           e.tmr0 = 1'b1; e.rcosc = 1'b1; end
            ST_WKT:  begin e.osc = 1'b1; e.tmr0 = 1'b1; e.tmr0_slow = 1'b1; end
            ST_RCW:  e.rcosc = 1'b1;
            ST_STAB: e.osc = 1'b1;
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lpm_mode_reg.sv
module lpm_mode_reg
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst)        mode_q <= '0;
        else if (wr_en) mode_q <= wdata;
    end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
(
    input  lpm_state_e state,
    input  logic       int0,
    input  logic       int1,
    input  logic       tmr0_match,
    input  logic       rcwdt_evt,
    output logic       hit,
    output wake_src_e  src
);
    logic ext;
    assign ext = int0 | int1;

    always_comb begin
        case (state)
            ST_STOP: hit = ext;
            ST_WKT:  hit = ext | tmr0_match;
            ST_RCW:  hit = ext | rcwdt_evt;
            default: hit = 1'b0;
        endcase
        if (int0)                src = SRC_INT0;
        else if (int1)           src = SRC_INT1;
        else if (state == ST_WKT) src = SRC_TMR0;
        else                     src = SRC_RCWDT;
    end
endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (busy && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign done = busy && (cnt == '0);

    // R7: countdown advances by exactly one per busy cycle
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int IRQ_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic             stop_req,
    input  logic [IRQ_W-1:0] irq_flags,
    input  logic             int0,
    input  logic             int1,
    input  logic             tmr0_match,
    input  logic             rcwdt_evt,
    input  logic [CNT_W-1:0] stab_cycles,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             presc_en,
    output logic             tmr0_clk_en,
    output logic             tmr0_slow_sel,
    output logic             rcosc_en,
    output logic             wake_pulse,
    output logic [1:0]       wake_src,
    output logic [1:0]       mode_q
);
    lpm_state_e state, state_n;
    wake_src_e  qual_src, src_q;
    logic       hit, cnt_done, irq_any, go_active, cnt_load;
    clk_en_t    en;

    assign irq_any = |irq_flags;

    lpm_mode_reg u_mode (
        .clk(clk), .rst(rst),
        .wr_en(mode_wr && state == ST_ACT),
        .wdata(mode_wdata), .mode_q(mode_q)
    );

    lpm_wake_qual u_qual (
        .state(state), .int0(int0), .int1(int1),
        .tmr0_match(tmr0_match), .rcwdt_evt(rcwdt_evt),
        .hit(hit), .src(qual_src)
    );

    assign cnt_load = hit && (state == ST_STOP || state == ST_RCW);

    lpm_stab_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(stab_cycles),
        .busy(state == ST_STAB), .done(cnt_done)
    );

    always_comb begin
        state_n   = state;
        go_active = 1'b0;
        case (state)
            ST_ACT:  if (stop_req && !irq_any) state_n = mode_to_state(mode_q);
            ST_STOP,
            ST_RCW:  if (hit) state_n = ST_STAB;
            ST_WKT:  if (hit) begin state_n = ST_ACT; go_active = 1'b1; end
            ST_STAB: if (cnt_done) begin state_n = ST_ACT; go_active = 1'b1; end
            default: state_n = ST_ACT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_ACT;
            src_q      <= SRC_INT0;
            wake_pulse <= 1'b0;
        end else begin
            state      <= state_n;
            wake_pulse <= go_active;
            if (hit) src_q <= qual_src;
        end
    end

    assign en            = gate_map(state);
    assign cpu_clk_en    = en.cpu;
    assign osc_en        = en.osc;
    assign presc_en      = en.presc;
    assign tmr0_clk_en   = en.tmr0;
    assign tmr0_slow_sel = en.tmr0_slow;
    assign rcosc_en      = en.rcosc;
    assign wake_src      = src_q;

    // R3: a pending request vetoes the stop
    p_irq_veto_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACT && stop_req && irq_any) |=> cpu_clk_en);
    // R2: a clean stop strobe gates the CPU clock next cycle
    p_enter_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACT && stop_req && !irq_any) |=> !cpu_clk_en);
    // R8: timer-mode release restarts the CPU at once with a pulse
    p_wkt_quick_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WKT && hit) |=> (cpu_clk_en && wake_pulse));
    // R9: pulse lasts a single cycle
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    // R12: mode field frozen while asleep
    p_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (state != ST_ACT) |=> $stable(mode_q));
endmodule

// File: tb/lpm_seq_tb.sv
module lpm_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IRQ_W = 16;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst, mode_wr, stop_req, int0, int1, tmr0_match, rcwdt_evt;
    logic [1:0] mode_wdata;
    logic [IRQ_W-1:0] irq_flags;
    logic [CNT_W-1:0] stab_cycles;
    logic cpu_clk_en, osc_en, presc_en, tmr0_clk_en, tmr0_slow_sel, rcosc_en;
    logic wake_pulse;
    logic [1:0] wake_src, mode_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_seq #(.IRQ_W(IRQ_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .stop_req(stop_req), .irq_flags(irq_flags), .int0(int0), .int1(int1),
        .tmr0_match(tmr0_match), .rcwdt_evt(rcwdt_evt), .stab_cycles(stab_cycles),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .presc_en(presc_en),
        .tmr0_clk_en(tmr0_clk_en), .tmr0_slow_sel(tmr0_slow_sel), .rcosc_en(rcosc_en),
        .wake_pulse(wake_pulse), .wake_src(wake_src), .mode_q(mode_q)
    );

    typedef struct { int src; int cyc; } exp_t;
    exp_t exp_q[$];

    int cyc = 0;
    int n_total = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // order {cpu, osc, presc, tmr0, slow, rcosc}
    task automatic chk_en(input string tag, input logic [5:0] expv);
        logic [5:0] a;
        a = {cpu_clk_en, osc_en, presc_en, tmr0_clk_en, tmr0_slow_sel, rcosc_en};
        chk(a == expv, tag, int'(a), int'(expv));
    endtask

    task automatic push_exp(input int src, input int due);
        exp_t e;
        e.src = src;
        e.cyc = due;
        exp_q.push_back(e);
    endtask

    task automatic do_stop(input logic [1:0] m);
        mode_wr = 1'b1; mode_wdata = m;
        step(1);
        mode_wr = 1'b0; stop_req = 1'b1;
        step(1);
        stop_req = 1'b0;
    endtask

    // 0:int0 1:int1 2:tmr0 3:rcwdt ; returns cycle count at drive time
    task automatic fire(input int which, output int c);
        c = cyc;
        case (which)
            0: int0 = 1'b1;
            1: int1 = 1'b1;
            2: tmr0_match = 1'b1;
            default: rcwdt_evt = 1'b1;
        endcase
        step(1);
        int0 = 1'b0; int1 = 1'b0; tmr0_match = 1'b0; rcwdt_evt = 1'b0;
    endtask

    // monitor: every pulse must match the next expected item
    always @(negedge clk) begin
        if (!rst && wake_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected wake_pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(wake_src) == e.src, "R9 wake_src", int'(wake_src), e.src);
                chk(cyc == e.cyc, "R7/R8 pulse cycle", cyc, e.cyc);
                chk(cpu_clk_en == 1'b1, "R9 cpu on with pulse", int'(cpu_clk_en), 1);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int c;
        int n;
        rst = 1'b1; mode_wr = 1'b0; mode_wdata = 2'b00; stop_req = 1'b0;
        irq_flags = '0; int0 = 1'b0; int1 = 1'b0; tmr0_match = 1'b0; rcwdt_evt = 1'b0;
        n = 5;
        stab_cycles = CNT_W'(n);
        step(3);
        chk_en("R1 reset enables", 6'b111101);
        chk(mode_q == 2'b00, "R1 reset mode", int'(mode_q), 0);
        chk(wake_pulse == 1'b0, "R1 reset pulse", int'(wake_pulse), 0);
        rst = 1'b0;
        step(1);

        // R2: mode write alone does nothing; R12 readback while active
        mode_wr = 1'b1; mode_wdata = 2'b01; step(1); mode_wr = 1'b0; step(2);
        chk_en("R2 write only", 6'b111101);
        chk(mode_q == 2'b01, "R12 write while active", int'(mode_q), 1);

        // R10: wake events while active
        fire(0, c); fire(3, c); step(2);
        chk_en("R10 active ignores wake", 6'b111101);

        // R3: pending interrupt vetoes stop
        irq_flags = IRQ_W'(1) << 9;
        stop_req = 1'b1; step(1); stop_req = 1'b0;
        chk_en("R3 veto", 6'b111101);
        step(1);
        chk_en("R3 veto holds", 6'b111101);
        irq_flags = '0;

        // R4: full stop
        do_stop(2'b00);
        chk_en("R4 stop enables", 6'b000000);
        fire(2, c); fire(3, c); step(2);
        chk_en("R4 timer/wdt ignored", 6'b000000);
        mode_wr = 1'b1; mode_wdata = 2'b01; step(1); mode_wr = 1'b0;
        chk(mode_q == 2'b00, "R12 write ignored asleep", int'(mode_q), 0);
        fire(1, c);
        push_exp(1, c + n + 2);
        chk_en("R7 countdown enables", 6'b010000);
        // R11: stray stop strobe and interrupt during countdown
        stop_req = 1'b1; int0 = 1'b1; step(1); stop_req = 1'b0; int0 = 1'b0;
        while (cyc < c + n + 1) step(1);
        chk(cpu_clk_en == 1'b0, "R7 cpu still off before end", int'(cpu_clk_en), 0);
        step(1);
        chk_en("R7 active after countdown", 6'b111101);
        step(2);

        // R5: wake-up-timer mode, code 10
        do_stop(2'b10);
        chk_en("R5 wkt enables", 6'b010110);
        fire(3, c); step(2);
        chk_en("R5 wdt ignored", 6'b010110);
        fire(2, c);
        push_exp(2, c + 1);
        chk(cpu_clk_en == 1'b1, "R8 immediate restart", int'(cpu_clk_en), 1);
        step(2);

        // R5 with code 11, R9 priority int1 over timer
        do_stop(2'b11);
        chk_en("R5 wkt code 11", 6'b010110);
        c = cyc; int1 = 1'b1; tmr0_match = 1'b1;
        push_exp(1, c + 1);
        step(1); int1 = 1'b0; tmr0_match = 1'b0;
        step(2);

        // R6: RC-watchdog mode, zero countdown
        n = 0; stab_cycles = '0;
        do_stop(2'b01);
        chk_en("R6 rcw enables", 6'b000001);
        fire(2, c); step(2);
        chk_en("R6 timer ignored", 6'b000001);
        fire(3, c);
        push_exp(3, c + n + 2);
        while (cyc < c + n + 2) step(1);
        chk_en("R6 woken", 6'b111101);
        step(2);

        // R9: int0 over int1 in full stop
        do_stop(2'b00);
        c = cyc; int0 = 1'b1; int1 = 1'b1;
        push_exp(0, c + n + 2);
        step(1); int0 = 1'b0; int1 = 1'b0;
        step(4);

        // R13: reset while asleep
        do_stop(2'b01);
        chk_en("R13 asleep before reset", 6'b000001);
        rst = 1'b1; step(1);
        chk_en("R13 reset wakes", 6'b111101);
        chk(mode_q == 2'b00, "R13 mode cleared", int'(mode_q), 0);
        rst = 1'b0; step(3);

        chk(exp_q.size() == 0, "R9 all expected pulses seen", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule